// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block runs a full-scan test of a circuit whose flops form a single shift chain. It steps through a list of combinational test vectors held in an external, asynchronously read vector store. For each vector it shifts the present-state pattern into the chain, spends one clock in functional mode with the vector's primary inputs applied so the chain captures the next state, and then shifts that response out while the next pattern goes in. The shifted-out bits and the primary outputs seen during the capture clock are compared with expected values stored with each vector.

A run is started with a one-cycle `start` request and lasts exactly (NUM_VEC+1)*CHAIN_LEN + NUM_VEC clocks. A one-cycle `done` pulse closes it, after which `pass_o` and the saturating mismatch count give the verdict. Chain length, vector count, input/output widths and counter width are parameters.

Top module: `scan_seq_top`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `scan_en_o` and `scan_in_o` are 0, `pi_o` is 0, the mismatch count is 0 and `pass_o` is 1.
- R2: Each vector is loaded in CHAIN_LEN consecutive cycles with `scan_en_o`=1; in the k-th of them (k from 0) `scan_in_o` equals bit CHAIN_LEN-1-k of the vector's state pattern (most significant bit first), and `pi_o` is 0 while shifting.
- R3: Every load is followed by exactly one cycle with `scan_en_o`=0 in which `pi_o` equals that vector's primary-input pattern.
- R4: While vector i>0 is loaded, the k-th shift cycle compares `scan_out_i` with bit CHAIN_LEN-1-k of the expected next state of vector i-1; each differing bit adds one to the count. No compare is made while the first vector loads.
- R5: In each capture cycle `po_i` is compared with the vector's expected outputs; any difference adds exactly one to the count.
- R6: After the last capture, one more block of CHAIN_LEN shift cycles unloads the final response (compared as in R4) while `scan_in_o` is 0.
- R7: `busy_o` is high for exactly (NUM_VEC+1)*CHAIN_LEN + NUM_VEC consecutive cycles, starting in the cycle after `start_i` is sampled high while idle.
- R8: `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls; then `pass_o` is 1 if and only if the count is 0.
- R9: The mismatch count saturates at 2^ERR_W-1 and is cleared when a run starts.
- R10: `start_i` while a run is in progress has no effect on the schedule or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| vec_idx_o | output | $clog2(NUM_VEC+1) | Index of the vector being loaded or captured |
| vec_state_i | input | CHAIN_LEN | State pattern of the addressed vector |
| vec_pi_i | input | PI_W | Primary-input pattern of the addressed vector |
| vec_po_exp_i | input | PO_W | Expected primary outputs of the addressed vector |
| vec_ns_exp_i | input | CHAIN_LEN | Expected next state of the addressed vector |
| scan_en_o | output | 1 | 1 = chain shifts, 0 = functional capture |
| scan_in_o | output | 1 | Serial data into the chain |
| pi_o | output | PI_W | Primary inputs to the circuit under test |
| scan_out_i | input | 1 | Serial data from the chain's last flop |
| po_i | input | PO_W | Primary outputs of the circuit under test |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | No mismatch counted |
| err_cnt_o | output | ERR_W | Saturating mismatch count |

## Verification
The unload compare of one response and the load of the next pattern share every shift cycle, so a fault in the overlap shows up either as a wrong `scan_in_o` bit or as a count that is off by the bits compared against the wrong vector. The bench models the chain and a small functional circuit itself, sweeps many pattern sets, and injects flips into chosen expected next-state and output values, including the first bit of the first unload, the last bit of the final unload and enough flips to saturate the counter. Each cycle's `scan_in_o`, `scan_en_o` and `pi_o` are judged against a schedule computed from the cycle number, and the final count against the number of injected flips.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_CAPT  = 2'd2
    } phase_e;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 4,
    parameter int NUM_VEC   = 3,
    localparam int BW       = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
    localparam int VC_W     = $clog2(NUM_VEC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output phase_e          phase_o,
    output logic [BW-1:0]   bit_o,
    output logic [VC_W-1:0] vec_o,
    output logic            go_o,
    output logic            done_o
);

    localparam logic [BW-1:0]   LAST_BIT = BW'(CHAIN_LEN - 1);
    localparam logic [VC_W-1:0] FINAL    = VC_W'(NUM_VEC);

    typedef struct packed {
        phase_e          phase;
        logic [BW-1:0]   bit_idx;
        logic [VC_W-1:0] vec;
        logic            done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  go_d;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        go_d        = 1'b0;
        case (ctrl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    ctrl_d.phase   = PH_SHIFT;
                    ctrl_d.bit_idx = '0;
                    ctrl_d.vec     = '0;
                    go_d           = 1'b1;
                end
            end
            PH_SHIFT: begin
                if (ctrl_q.bit_idx == LAST_BIT) begin
                    ctrl_d.bit_idx = '0;
                    if (ctrl_q.vec == FINAL) begin
                        ctrl_d.phase = PH_IDLE;
                        ctrl_d.vec   = '0;
                        ctrl_d.done  = 1'b1;
                    end else begin
                        ctrl_d.phase = PH_CAPT;
                    end
                end else begin
                    ctrl_d.bit_idx = ctrl_q.bit_idx + 1'b1;
                end
            end
            PH_CAPT: begin
                ctrl_d.phase   = PH_SHIFT;
                ctrl_d.bit_idx = '0;
                ctrl_d.vec     = ctrl_q.vec + 1'b1;
            end
            default: begin
                ctrl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.phase   <= PH_IDLE;
            ctrl_q.bit_idx <= '0;
            ctrl_q.vec     <= '0;
            ctrl_q.done    <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign phase_o = ctrl_q.phase;
    assign bit_o   = ctrl_q.bit_idx;
    assign vec_o   = ctrl_q.vec;
    assign go_o    = go_d;
    assign done_o  = ctrl_q.done;

    AST_CAPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_CAPT) |=> (ctrl_q.phase == PH_SHIFT)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |=> !ctrl_q.done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |-> (ctrl_q.phase == PH_IDLE)); // R8

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_SHIFT && ctrl_q.bit_idx != LAST_BIT)
            |=> (ctrl_q.phase == PH_SHIFT && ctrl_q.bit_idx == $past(ctrl_q.bit_idx) + 1'b1)); // R10

endmodule

// File: rtl/scan_seq_drive.sv
module scan_seq_drive
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 4,
    parameter int PI_W      = 2,
    localparam int BW       = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
    input  phase_e                 phase_i,
    input  logic [BW-1:0]          sel_i,
    input  logic                   filler_i,
    input  logic [CHAIN_LEN-1:0]   vec_state_i,
    input  logic [PI_W-1:0]        vec_pi_i,
    output logic                   scan_en_o,
    output logic                   scan_in_o,
    output logic [PI_W-1:0]        pi_o
);

    always_comb begin
        scan_en_o = 1'b0;
        scan_in_o = 1'b0;
        pi_o      = '0;
        case (phase_i)
            PH_SHIFT: begin
                scan_en_o = 1'b1;
                scan_in_o = filler_i ? 1'b0 : vec_state_i[sel_i];
            end
            PH_CAPT: begin
                pi_o = vec_pi_i;
            end
            default: begin
                scan_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/scan_seq_check.sv
module scan_seq_check #(
    parameter int CHAIN_LEN = 4,
    parameter int PO_W      = 2,
    parameter int ERR_W     = 8,
    localparam int BW       = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 unload_i,
    input  logic                 capt_i,
    input  logic [BW-1:0]        sel_i,
    input  logic                 scan_out_i,
    input  logic [PO_W-1:0]      po_i,
    input  logic [PO_W-1:0]      po_exp_i,
    input  logic [CHAIN_LEN-1:0] ns_exp_i,
    output logic [ERR_W-1:0]     cnt_o
);

    localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

    typedef struct packed {
        logic [CHAIN_LEN-1:0] ns_hold;
        logic [ERR_W-1:0]     cnt;
    } chk_t;

    chk_t chk_d, chk_q;
    logic bit_miss, po_miss, miss;

    always_comb begin
        bit_miss = unload_i && (scan_out_i != chk_q.ns_hold[sel_i]);
        po_miss  = capt_i && (po_i != po_exp_i);
        miss     = bit_miss || po_miss;

        chk_d = chk_q;
        if (capt_i) begin
            chk_d.ns_hold = ns_exp_i;
        end
        if (clr_i) begin
            chk_d.cnt = '0;
        end else if (miss && (chk_q.cnt != CNT_MAX)) begin
            chk_d.cnt = chk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_q.ns_hold <= '0;
            chk_q.cnt     <= '0;
        end else begin
            chk_q <= chk_d;
        end
    end

    assign cnt_o = chk_q.cnt;

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_q.cnt == CNT_MAX && !clr_i) |=> (chk_q.cnt == CNT_MAX)); // R9

    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (chk_q.cnt == $past(chk_q.cnt)
                    || chk_q.cnt == $past(chk_q.cnt) + 1'b1)); // R4

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (chk_q.cnt == '0)); // R9

    AST_NO_CMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!unload_i && !capt_i && !clr_i) |=> $stable(chk_q.cnt)); // R10

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 4,
    parameter int NUM_VEC   = 3,
    parameter int PI_W      = 2,
    parameter int PO_W      = 2,
    parameter int ERR_W     = 8,
    localparam int VC_W     = $clog2(NUM_VEC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic [VC_W-1:0]      vec_idx_o,
    input  logic [CHAIN_LEN-1:0] vec_state_i,
    input  logic [PI_W-1:0]      vec_pi_i,
    input  logic [PO_W-1:0]      vec_po_exp_i,
    input  logic [CHAIN_LEN-1:0] vec_ns_exp_i,
    output logic                 scan_en_o,
    output logic                 scan_in_o,
    output logic [PI_W-1:0]      pi_o,
    input  logic                 scan_out_i,
    input  logic [PO_W-1:0]      po_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 pass_o,
    output logic [ERR_W-1:0]     err_cnt_o
);

    localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [BW-1:0]   LAST_BIT = BW'(CHAIN_LEN - 1);
    localparam logic [VC_W-1:0] FINAL    = VC_W'(NUM_VEC);
    localparam logic [VC_W-1:0] LAST_VEC = VC_W'(NUM_VEC - 1);

    phase_e          phase;
    logic [BW-1:0]   bit_idx;
    logic [BW-1:0]   sel;
    logic [VC_W-1:0] vec;
    logic            go;
    logic            filler;
    logic            unload;
    logic            capt;

    scan_seq_ctrl #(
        .CHAIN_LEN (CHAIN_LEN),
        .NUM_VEC   (NUM_VEC)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .phase_o (phase),
        .bit_o   (bit_idx),
        .vec_o   (vec),
        .go_o    (go),
        .done_o  (done_o)
    );

    always_comb begin
        sel       = LAST_BIT - bit_idx;
        filler    = (vec == FINAL);
        unload    = (phase == PH_SHIFT) && (vec != '0);
        capt      = (phase == PH_CAPT);
        vec_idx_o = filler ? LAST_VEC : vec;
        busy_o    = (phase != PH_IDLE);
    end

    scan_seq_drive #(
        .CHAIN_LEN (CHAIN_LEN),
        .PI_W      (PI_W)
    ) u_drive (
        .phase_i     (phase),
        .sel_i       (sel),
        .filler_i    (filler),
        .vec_state_i (vec_state_i),
        .vec_pi_i    (vec_pi_i),
        .scan_en_o   (scan_en_o),
        .scan_in_o   (scan_in_o),
        .pi_o        (pi_o)
    );

    scan_seq_check #(
        .CHAIN_LEN (CHAIN_LEN),
        .PO_W      (PO_W),
        .ERR_W     (ERR_W)
    ) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (go),
        .unload_i   (unload),
        .capt_i     (capt),
        .sel_i      (sel),
        .scan_out_i (scan_out_i),
        .po_i       (po_i),
        .po_exp_i   (vec_po_exp_i),
        .ns_exp_i   (vec_ns_exp_i),
        .cnt_o      (err_cnt_o)
    );

    assign pass_o = (err_cnt_o == '0);

    AST_FILLER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en_o && vec == FINAL) |-> !scan_in_o); // R6

    AST_SHIFT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_o |-> busy_o); // R2

    AST_PI_QUIET_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_o |-> (pi_o == '0)); // R2

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o)); // R7

endmodule

// File: tb/test_scan_seq_top.sv
`timescale 1ns/1ps
module test_scan_seq_top;

    localparam int L     = 4;
    localparam int N     = 3;
    localparam int PI_W  = 2;
    localparam int PO_W  = 2;
    localparam int ERR_W = 3;
    localparam int VC_W  = $clog2(N + 1);
    localparam int RUN_LEN = (N + 1) * L + N;
    localparam int CNT_MAX = (1 << ERR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #4 clk = ~clk;

    logic [VC_W-1:0]  vec_idx;
    logic [L-1:0]     vec_state, vec_ns_exp;
    logic [PI_W-1:0]  vec_pi, pi;
    logic [PO_W-1:0]  vec_po_exp, po;
    logic             scan_en, scan_in, scan_out, busy, done, pass;
    logic [ERR_W-1:0] err_cnt;

    logic [L-1:0]    m_state  [N];
    logic [PI_W-1:0] m_pi     [N];
    logic [PO_W-1:0] m_po_exp [N];
    logic [L-1:0]    m_ns_exp [N];

    assign vec_state  = m_state[vec_idx];
    assign vec_pi     = m_pi[vec_idx];
    assign vec_po_exp = m_po_exp[vec_idx];
    assign vec_ns_exp = m_ns_exp[vec_idx];

    // Bench model of the circuit under test: chain flop 0 takes scan_in,
    // the last flop drives scan_out.
    logic [L-1:0] chain;
    function automatic logic [L-1:0] f_ns(input logic [L-1:0] s, input logic [PI_W-1:0] p);
        return {s[L-2:0], s[L-1]} ^ {p, p};
    endfunction
    function automatic logic [PO_W-1:0] f_po(input logic [L-1:0] s, input logic [PI_W-1:0] p);
        return s[1:0] ^ s[3:2] ^ p;
    endfunction
    always_ff @(posedge clk) begin
        if (scan_en) chain <= {chain[L-2:0], scan_in};
        else if (busy) chain <= f_ns(chain, pi);
    end
    assign scan_out = chain[L-1];
    assign po = f_po(chain, pi);

    scan_seq_top #(
        .CHAIN_LEN (L), .NUM_VEC (N), .PI_W (PI_W), .PO_W (PO_W), .ERR_W (ERR_W)
    ) i_scan_seq_top (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .vec_idx_o (vec_idx), .vec_state_i (vec_state), .vec_pi_i (vec_pi),
        .vec_po_exp_i (vec_po_exp), .vec_ns_exp_i (vec_ns_exp),
        .scan_en_o (scan_en), .scan_in_o (scan_in), .pi_o (pi),
        .scan_out_i (scan_out), .po_i (po),
        .busy_o (busy), .done_o (done), .pass_o (pass), .err_cnt_o (err_cnt)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(8ns * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic run_case(input int seed);
        logic [L-1:0]    ns_flip [N];
        logic [PO_W-1:0] po_flip [N];
        int exp_err, c, v, k, p;
        for (int i = 0; i < N; i++) begin
            m_state[i] = L'(seed * 5 + i * 3 + 1);
            m_pi[i]    = PI_W'(seed + i);
            ns_flip[i] = '0;
            po_flip[i] = '0;
        end
        case (seed % 8)
            1: ns_flip[0] = 4'h8;                  // first unload bit
            2: ns_flip[2] = 4'h1;                  // last bit of final unload
            3: po_flip[1] = 2'h3;                  // one count for two bits
            4: begin ns_flip[1] = 4'h5; po_flip[0] = 2'h1; end
            5: for (int i = 0; i < N; i++) begin ns_flip[i] = 4'hF; po_flip[i] = 2'h2; end
            6: begin ns_flip[0] = 4'hF; ns_flip[1] = 4'h7; end
            7: begin ns_flip[0] = 4'hF; ns_flip[2] = 4'hF; end
            default: ;
        endcase
        exp_err = 0;
        for (int i = 0; i < N; i++) begin
            m_ns_exp[i] = f_ns(m_state[i], m_pi[i]) ^ ns_flip[i];
            m_po_exp[i] = f_po(m_state[i], m_pi[i]) ^ po_flip[i];
            exp_err += $countones(ns_flip[i]) + ((po_flip[i] != 0) ? 1 : 0);
        end
        if (exp_err > CNT_MAX) exp_err = CNT_MAX;

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 0;
        while (busy && c < 60) begin
            if (c < N * (L + 1)) begin
                v = c / (L + 1);
                p = c % (L + 1);
                if (p < L) begin
                    chk("R2 scan_en", 32'(scan_en), 1);
                    chk("R2 scan_in", 32'(scan_in), 32'(m_state[v][L-1-p]));
                    chk("R2 pi idle", 32'(pi), 0);
                end else begin
                    chk("R3 capture", 32'(scan_en), 0);
                    chk("R3 pi", 32'(pi), 32'(m_pi[v]));
                end
            end else begin
                k = c - N * (L + 1);
                chk("R6 unload scan_en", 32'(scan_en), 1);
                chk("R6 filler", 32'(scan_in), 0);
            end
            chk("R7 done low", 32'(done), 0);
            if ((seed % 8) == 7 && c == 6) start = 1'b1;  // R10 poke
            if ((seed % 8) == 7 && c == 8) start = 1'b0;
            @(negedge clk);
            c++;
        end
        start = 1'b0;
        chk("R7 run length", 32'(c), 32'(RUN_LEN));
        chk("R8 done", 32'(done), 1);
        chk("R4 R5 R9 count", 32'(err_cnt), 32'(exp_err));
        chk("R8 pass", 32'(pass), 32'(exp_err == 0));
        @(negedge clk);
        chk("R8 done one cycle", 32'(done), 0);
        chk("R10 idle count", 32'(err_cnt), 32'(exp_err));
        chk("R10 idle busy", 32'(busy), 0);
    endtask

    initial begin
        chain = '0;
        for (int i = 0; i < N; i++) begin
            m_state[i] = '0; m_pi[i] = '0; m_po_exp[i] = '0; m_ns_exp[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 scan_en", 32'(scan_en), 0);
        chk("R1 scan_in", 32'(scan_in), 0);
        chk("R1 pi", 32'(pi), 0);
        chk("R1 count", 32'(err_cnt), 0);
        chk("R1 pass", 32'(pass), 1);
        for (int s = 0; s < 32; s++) begin
            run_case(s);
            repeat (s % 3) @(negedge clk);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule